// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block is the device side of one receive channel. Host software keeps a power-of-two ring of buffer descriptors in its memory and tells the engine how far the ring has been stocked by writing a producer index. Whenever the engine's own index differs from that producer index and the engine is enabled, it reads the next descriptor through a single-outstanding request/response memory port. The descriptor is one 32-bit word that carries bits [35:4] of a 36-bit buffer address.

One incoming frame, delivered as a stream of 32-bit beats, is written into that buffer at consecutive word addresses. When the last beat has been acknowledged, the engine writes the index of the descriptor it just filled into a small status area in host memory. After that write is acknowledged it pulses an interrupt and moves to the next ring slot. Frames that arrive when no descriptor is available are discarded, and a sticky overflow flag records that this happened.

Register port (word address on `reg_addr`): 0 = control (bit 0 enable, bit 1 write-one-to-clear overflow, bits [7:4] log2 of ring size), 1 = ring base (bits [27:0] hold address bits [35:8]), 2 = status base (bits [31:0] hold address bits [35:4]), 3 = producer index.

Top module: `rx_ring_dma`

## Requirements
- R1: While reset is asserted and right after it is released, `irq`, `overflow`, `mem_req_valid` and `frm_ready` are all 0. The reset state is disabled, the ring size is 256, and all indexes are 0.
- R2: A descriptor read uses address `{ring_base[27:0], 8'h00} + 4*index`, and the engine index starts at 0.
- R3: The buffer address is `{desc[31:4], 8'h00}`: descriptor bits [3:0] are forced to zero. Frame beat k is written to that address plus 4*k.
- R4: After a frame, the engine writes `{20'b0, index}` to address `{status_base, 4'h0}`, where index is the slot just filled. Bits [31:12] of that word are zero.
- R5: `irq` is a one-cycle pulse raised only in the cycle after the response to the status write, and exactly once per filled frame.
- R6: A producer index write keeps bits [11:3] after masking to the ring size (2^ctrl[7:4], clamped to 8..4096), so the value is rounded down to a multiple of eight. The engine index wraps from size-1 to 0.
- R7: When the engine index equals the producer index, no descriptor is read. A frame arriving then is consumed without any memory write or interrupt, and `overflow` is set. Writing control with bit 1 set clears `overflow`.
- R8: With enable at 0 no descriptor is read and arriving frames are dropped. Clearing enable during a frame lets that frame finish and report normally.
- R9: At most one memory request is outstanding. A request that is not accepted keeps its valid, address and direction until it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| frm_valid | input | 1 | Frame beat valid |
| frm_data | input | 32 | Frame beat data |
| frm_last | input | 1 | Final beat of frame |
| frm_ready | output | 1 | Frame beat accepted |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 36 | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response (read data or write done) |
| mem_rsp_rdata | input | 32 | Read data |
| irq | output | 1 | Frame-complete pulse |
| overflow | output | 1 | Sticky frame-dropped flag |

## Verification
A corrupted engine index first shows up in the address of the next descriptor read and in the status word. Both are visible within one frame, at the latest at the following interrupt. A wrong comparison between the engine and producer indexes shows up either as a descriptor read when none is allowed or as a frame dropped with `overflow` set when a slot was free, and either appears within a few cycles of the frame arriving. Errors in the ordering of the status write and the interrupt appear at the very next interrupt edge.

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int IW       = 12,
  parameter int LG_MIN   = 3,
  parameter int LG_RESET = 8
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        frm_valid,
  input  logic [31:0] frm_data,
  input  logic        frm_last,
  output logic        frm_ready,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [35:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_rdata,
  output logic        irq,
  output logic        overflow
);
  localparam int AW = 36;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_FWAIT, S_FILL, S_DACK, S_WB, S_WACK, S_DROP
  } state_t;

  state_t         state;
  logic           en, mid, last_q;
  logic [3:0]     lg;
  logic [27:0]    ring_base;
  logic [31:0]    stat_base;
  logic [IW-1:0]  prod, idx, mask;
  logic [AW-1:0]  cur_addr;
  logic           go, room, accept;

  function automatic logic [3:0] clamp_lg(input logic [3:0] v);
    if (int'(v) < LG_MIN) return 4'(LG_MIN);
    if (int'(v) > IW)     return 4'(IW);
    return v;
  endfunction

  assign mask   = {IW{1'b1}} >> (4'(IW) - lg);
  assign room   = (idx != prod);
  assign go     = en || mid;
  assign accept = mem_req_valid && mem_req_ready;

  assign mem_req_valid = (state == S_FETCH) || (state == S_WB) ||
                         (state == S_FILL && frm_valid && go);
  assign mem_req_write = (state != S_FETCH);
  assign frm_ready     = (state == S_DROP) ||
                         (state == S_FILL && go && mem_req_ready);

  always_comb begin
    mem_req_wdata = frm_data;
    mem_req_addr  = cur_addr;
    case (state)
      S_FETCH: mem_req_addr = {ring_base, 8'h00} + {{(AW-IW-2){1'b0}}, idx, 2'b00};
      S_WB: begin
        mem_req_addr  = {stat_base, 4'h0};
        mem_req_wdata = {{(32-IW){1'b0}}, idx};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      en        <= 1'b0;
      mid       <= 1'b0;
      last_q    <= 1'b0;
      lg        <= 4'(LG_RESET);
      ring_base <= '0;
      stat_base <= '0;
      prod      <= '0;
      idx       <= '0;
      cur_addr  <= '0;
      irq       <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      irq <= 1'b0;

      if (reg_we) begin
        case (reg_addr)
          2'd0: begin
            en <= reg_wdata[0];
            lg <= clamp_lg(reg_wdata[7:4]);
          end
          2'd1: ring_base <= reg_wdata[27:0];
          2'd2: stat_base <= reg_wdata;
          2'd3: prod <= {reg_wdata[IW-1:3] & mask[IW-1:3], 3'b000};
        endcase
      end

      if (state == S_DROP && frm_valid)
        overflow <= 1'b1;
      else if (reg_we && reg_addr == 2'd0 && reg_wdata[1])
        overflow <= 1'b0;

      case (state)
        S_IDLE: begin
          if (en && room)   state <= S_FETCH;
          else if (frm_valid) state <= S_DROP;
        end
        S_FETCH: if (mem_req_ready) state <= S_FWAIT;
        S_FWAIT: if (mem_rsp_valid) begin
          cur_addr <= {mem_rsp_rdata[31:4], 8'h00};
          state    <= S_FILL;
        end
        S_FILL: begin
          if (!go) state <= S_IDLE;
          else if (frm_valid) begin
            mid <= 1'b1;
            if (mem_req_ready) begin
              last_q   <= frm_last;
              cur_addr <= cur_addr + AW'(4);
              state    <= S_DACK;
            end
          end
        end
        S_DACK: if (mem_rsp_valid) begin
          if (last_q) begin
            mid   <= 1'b0;
            state <= S_WB;
          end else begin
            state <= S_FILL;
          end
        end
        S_WB: if (mem_req_ready) state <= S_WACK;
        S_WACK: if (mem_rsp_valid) begin
          idx   <= (idx + 1'b1) & mask;
          irq   <= 1'b1;
          state <= S_IDLE;
        end
        S_DROP: if (frm_valid && frm_last) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  // R5
  irq_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mem_rsp_valid && state == S_WACK));

  // R7
  no_fetch_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mem_req_write) |-> (room && en));

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(state == S_DROP && frm_valid));

  // R4
  wb_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mem_req_write && state == S_WB) |=> (state == S_WACK && $stable(idx)));
endmodule

// File: tb/sim_rx_ring_dma.sv
module sim_rx_ring_dma;
  localparam int CLK_PERIOD = 10;
  localparam logic [35:0] RB   = 36'h100;
  localparam logic [35:0] STAT = 36'h40;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic        frm_valid = 0, frm_last = 0;
  logic [31:0] frm_data = 0;
  logic        frm_ready;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 0, mem_rsp_valid = 0;
  logic [35:0] mem_req_addr;
  logic [31:0] mem_req_wdata, mem_rsp_rdata = 0;
  logic        irq, overflow;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_dma u0 (.*);

  int total = 0, fails = 0;
  int req_cnt = 0, wr_cnt = 0, irq_cnt = 0, proto_err = 0, beats_acc = 0, cyc = 0;
  logic [31:0] mem [0:16383];
  logic [31:0] exp_data [0:7];
  logic [35:0] rd_last, pend_addr;
  logic [31:0] rdata_q;
  bit pend = 0, pend_wr = 0, wb_seen = 0;
  int lat = 0;
  bit en_m = 0;
  int m_idx = 0, m_prod = 0, m_mask = 255;

  function automatic void chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  function automatic logic [35:0] buf_a(int i);
    return 36'h4000 + 36'(i % 64) * 36'h100;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "WD", "watchdog expired", cyc, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
    if (!rst_n) pend = 0;
    else begin
      if (mem_req_valid && pend) proto_err++;
      if (mem_rsp_valid) begin
        if (pend_wr && pend_addr == STAT) wb_seen = 1;
        pend = 0;
      end
      if (mem_req_valid && mem_req_ready) begin
        req_cnt++;
        pend = 1; lat = $urandom % 3;
        pend_addr = mem_req_addr; pend_wr = mem_req_write;
        if (mem_req_write) begin
          mem[mem_req_addr[15:2]] = mem_req_wdata;
          wr_cnt++;
        end else begin
          rdata_q = mem[mem_req_addr[15:2]];
          rd_last = mem_req_addr;
        end
      end
      if (irq) begin
        chk(wb_seen, "R5", "irq before status write acknowledged", 0, 1);
        wb_seen = 0;
        irq_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (pend) begin
      mem_req_ready = 0;
      if (lat == 0) begin mem_rsp_valid = 1; mem_rsp_rdata = rdata_q; end
      else begin lat--; mem_rsp_valid = 0; end
    end else begin
      mem_rsp_valid = 0;
      mem_req_ready = ($urandom % 4) != 0;
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic push_frame(input int n);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      int t = 0;
      exp_data[k] = $urandom;
      frm_valid = 1; frm_data = exp_data[k]; frm_last = (k == n - 1);
      do begin @(posedge clk); t++; end while (!frm_ready && t < 2000);
      if (t >= 2000) chk(0, "R7", "frame beat never accepted", k, n);
      beats_acc++;
      @(negedge clk);
    end
    frm_valid = 0; frm_last = 0;
  endtask

  task automatic frame_case(input int n, input string tag);
    bit fill = en_m && (m_idx != m_prod);
    int ic = irq_cnt, wc = wr_cnt, t = 0;
    push_frame(n);
    if (fill) begin
      while (irq_cnt == ic && t < 500) begin @(negedge clk); t++; end
      chk(irq_cnt == ic + 1, "R5", {tag, " one irq per frame"}, irq_cnt - ic, 1);
      chk(rd_last == RB + 36'(4 * m_idx), "R2", "descriptor address", rd_last, RB + 36'(4 * m_idx));
      for (int k = 0; k < n; k++)
        chk(mem[(buf_a(m_idx) >> 2) + 36'(k)] == exp_data[k], "R3", {tag, " buffer word"},
            mem[(buf_a(m_idx) >> 2) + 36'(k)], exp_data[k]);
      chk(mem[STAT >> 2] == 32'(m_idx), "R4", "status word", mem[STAT >> 2], m_idx);
      mem[STAT >> 2] = 32'hFFFF_FFFF;
      m_idx = (m_idx + 1) & m_mask;
    end else begin
      repeat (20) @(negedge clk);
      chk(irq_cnt == ic, "R7", {tag, " dropped frame raised irq"}, irq_cnt - ic, 0);
      chk(wr_cnt == wc, "R7", {tag, " dropped frame wrote memory"}, wr_cnt - wc, 0);
      chk(overflow == 1, "R7", {tag, " overflow flag"}, overflow, 1);
    end
  endtask

  initial begin
    int rc, b0;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 16384; i++) mem[i] = 32'h0;
    for (int i = 0; i < 256; i++) mem[(RB >> 2) + 36'(i)] = 32'(buf_a(i) >> 4) | 32'(i & 15);
    mem[STAT >> 2] = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(irq == 0 && overflow == 0, "R1", "irq/overflow in reset", {irq, overflow}, 0);
    chk(mem_req_valid == 0 && frm_ready == 0, "R1", "req/ready in reset", {mem_req_valid, frm_ready}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(mem_req_valid == 0 && req_cnt == 0, "R1", "no request after reset", req_cnt, 0);

    wr_reg(2'd1, 32'(RB >> 8));
    wr_reg(2'd2, 32'(STAT >> 4));
    wr_reg(2'd0, 32'h41); en_m = 1; m_mask = 15;
    repeat (20) @(negedge clk);
    chk(req_cnt == 0, "R7", "no fetch when indexes equal", req_cnt, 0);
    frame_case(3, "R7 empty ring");
    wr_reg(2'd0, 32'h41);
    @(negedge clk);
    chk(overflow == 1, "R7", "write without clear bit keeps flag", overflow, 1);
    wr_reg(2'd0, 32'h43);
    @(negedge clk);
    chk(overflow == 0, "R7", "write-one clears overflow", overflow, 0);

    // R6 rounding: 13 -> 8
    wr_reg(2'd3, 32'd13); m_prod = 8;
    for (int i = 0; i < 9; i++) frame_case(1 + $urandom % 8, "R6 rounded producer");
    wr_reg(2'd0, 32'h43);

    // R6 masking and wrap: 0x7F0 in a 16-entry ring -> 0
    wr_reg(2'd3, 32'h7F0); m_prod = 0;
    for (int i = 0; i < 8; i++) frame_case(1 + $urandom % 8, "R6 wrap");
    chk(m_idx == 0, "R6", "model index wrapped", m_idx, 0);
    frame_case(2, "R6 full after wrap");
    wr_reg(2'd0, 32'h43);

    // R8 disable during a frame
    wr_reg(2'd3, 32'd8); m_prod = 8;
    b0 = beats_acc;
    fork
      frame_case(6, "R8 finish after disable");
      begin
        wait (beats_acc >= b0 + 1);
        wr_reg(2'd0, 32'h40);
        en_m = 0;
      end
    join
    rc = req_cnt;
    repeat (30) @(negedge clk);
    chk(req_cnt == rc, "R8", "no fetch while disabled", req_cnt - rc, 0);
    frame_case(2, "R8 drop while disabled");
    wr_reg(2'd0, 32'h43); en_m = 1;
    @(negedge clk);
    chk(overflow == 0, "R7", "overflow cleared again", overflow, 0);

    for (int i = 0; i < 40; i++) begin
      if (m_idx == m_prod) begin
        m_prod = (m_prod + 8) & m_mask;
        wr_reg(2'd3, 32'(m_prod));
      end
      frame_case(1 + $urandom % 8, "random");
    end
    chk(proto_err == 0, "R9", "request while one outstanding", proto_err, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule